// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front-End

This block sits on the device side of a 16-bit parallel NOR-style memory bus. It watches the active-low pins (chip enable, output enable, write enable, address valid and the device reset pin), a 23-bit address, the bus clock and a mode input that picks asynchronous or synchronous addressing. From these it decides which bus operation is in progress. The five operations are read, write, output-disable, standby and reset.

The pins are brought into the internal system clock through two-flop synchronisers. Edges are found by comparing each sample with the previous one. The address is latched by rules that depend on the mode. Write data is stored in a small register array on the first rising edge of write enable or chip enable. During a read, the word at the latched address is presented. The tri-state drivers for the data bus and the WAIT pin are modelled as enable outputs.

Top module: `pfl_front`

## Requirements
- R1: While the device reset pin is low, `bus_op_o` reads 4 (reset), both drive enables are low, and no write is stored, even if the other pins form a write.
- R2: With the reset pin high, chip enable low, output enable low and write enable high, `bus_op_o` reads 1 (read). Both drive enables are high, and `dq_o` carries the word stored at the latched address.
- R3: With the reset pin high, chip enable low, write enable low and output enable high, `bus_op_o` reads 2 (write) and both drive enables are low. The word on `dq_i` is stored at the latched address on the first rising edge of write enable or chip enable. When both rise in the same sample, exactly one store takes place.
- R4: When chip enable is high, `bus_op_o` reads 0 (standby). When chip enable is low and both output enable and write enable are high, `bus_op_o` reads 3 (output-disable). In both cases both drive enables are low.
- R5: With chip enable low, output enable and write enable both low is not a defined operation. It reads 0 (standby), and no drivers are enabled.
- R6: In asynchronous mode (`sync_mode_i`=0), the address follows the pins while address-valid is low. From the sample where address-valid rises, the address holds the value it had in the last low sample.
- R7: In synchronous mode (`sync_mode_i`=1), each low phase of address-valid latches the address once, on whichever event comes first. One event is a rising bus-clock edge while address-valid is low. The other is the rise of address-valid, which latches the value from the last low sample. Later clock edges in the same low phase change nothing.
- R8: The array word is selected by the top `BANK_BITS` address bits, placed above the low `WORD_BITS` address bits. Addresses that differ only in their top bit therefore reach different words.
- R9: The array is cleared by `rst_ni` alone. The device reset pin leaves the stored words unchanged.
- R10: During a read, `wait_o` sits at its deasserted level, `WAIT_IDLE` (default 0).

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all pins |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| sync_mode_i | input | 1 | 1 = synchronous address capture, 0 = asynchronous |
| bus_clk_i | input | 1 | Bus clock pin |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| adv_ni | input | 1 | Address valid, active low |
| dev_rst_ni | input | 1 | Device reset pin, active low |
| addr_i | input | AW | Word address |
| dq_i | input | DW | Data bus, input side |
| dq_o | output | DW | Data bus, output side |
| dq_oe_o | output | 1 | Data bus drive enable |
| wait_o | output | 1 | WAIT pin level |
| wait_oe_o | output | 1 | WAIT pin drive enable |
| bus_op_o | output | 3 | Current operation: 0 standby, 1 read, 2 write, 3 output-disable, 4 reset |

## Verification
The bench builds the block with the defaults: a 23-bit address, 16-bit words, one bank bit and three word bits, which gives 16 stored words. The bank bit is the top address bit, so a pair of addresses that differ only in bit 22 reaches distinct words. This exposes a wrong bank decode after a single write and read-back. Because the array is this small, the bench can check for a lost or doubled store by reading back exact addresses. The system reset check can also cover the whole array.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  typedef enum logic [2:0] {
    OP_STANDBY = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_OUTDIS  = 3'd3,
    OP_RESET   = 3'd4
  } bus_op_e;

  typedef struct packed {
    logic rst_n;
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic adv_n;
    logic bclk;
  } pins_t;

  localparam pins_t PINS_IDLE = '{rst_n: 1'b0, ce_n: 1'b1, oe_n: 1'b1,
                                  we_n: 1'b1, adv_n: 1'b1, bclk: 1'b0};
endpackage

// File: rtl/pfl_sync.sv
module pfl_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pfl_decode.sv
module pfl_decode
  import pfl_pkg::*;
(
  input  pins_t   pins_i,
  output bus_op_e op_o
);
  always_comb begin
    if (!pins_i.rst_n)                     op_o = OP_RESET;
    else if (pins_i.ce_n)                  op_o = OP_STANDBY;
    else if (!pins_i.oe_n && pins_i.we_n)  op_o = OP_READ;
    else if (pins_i.oe_n && !pins_i.we_n)  op_o = OP_WRITE;
    else if (pins_i.oe_n && pins_i.we_n)   op_o = OP_OUTDIS;
    else                                   op_o = OP_STANDBY; // undefined combination
  end
endmodule

// File: rtl/pfl_addr_latch.sv
module pfl_addr_latch #(
  parameter int AW = 23
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_mode_i,
  input  logic          dev_rst_n_i,
  input  logic          adv_n_i,
  input  logic          adv_prev_n_i,
  input  logic          bclk_rise_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] addr_prev_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] hold_q;
  logic          done_q;
  logic          adv_fall, adv_rise;

  assign adv_fall = !adv_n_i && adv_prev_n_i;
  assign adv_rise = adv_n_i && !adv_prev_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      done_q <= 1'b0;
    end else if (!dev_rst_n_i) begin
      done_q <= 1'b0;
    end else if (!sync_mode_i) begin
      done_q <= 1'b0;
      if (!adv_n_i) hold_q <= addr_i;
    end else if (adv_fall) begin
      // new low phase: clock edge in the same sample already captures
      done_q <= bclk_rise_i;
      if (bclk_rise_i) hold_q <= addr_i;
    end else if (!adv_n_i) begin
      if (!done_q && bclk_rise_i) begin
        hold_q <= addr_i;
        done_q <= 1'b1;
      end
    end else if (adv_rise && !done_q) begin
      hold_q <= addr_prev_i;
      done_q <= 1'b1;
    end
  end

  assign addr_o = (!sync_mode_i && !adv_n_i) ? addr_i : hold_q;
endmodule

// File: rtl/pfl_array.sv
module pfl_array #(
  parameter int DW    = 16,
  parameter int IDX_W = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/pfl_front.sv
module pfl_front
  import pfl_pkg::*;
#(
  parameter int   AW        = 23,
  parameter int   DW        = 16,
  parameter int   BANK_BITS = 1,
  parameter int   WORD_BITS = 3,
  parameter logic WAIT_IDLE = 1'b0,
  localparam int  IDX_W     = BANK_BITS + WORD_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_mode_i,
  input  logic          bus_clk_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          adv_ni,
  input  logic          dev_rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          wait_o,
  output logic          wait_oe_o,
  output logic [2:0]    bus_op_o
);
  pins_t           pins_raw, pins_s, pins_p;
  logic [AW+DW-1:0] bus_s;
  logic [AW-1:0]   addr_s, addr_p, eff_addr, eff_p;
  logic [DW-1:0]   dq_s, dq_p, rdata;
  logic            mode_s;
  bus_op_e         op, op_p;
  logic            wr_stb;
  logic [IDX_W-1:0] ridx, widx;

  assign pins_raw = '{rst_n: dev_rst_ni, ce_n: ce_ni, oe_n: oe_ni,
                      we_n: we_ni, adv_n: adv_ni, bclk: bus_clk_i};

  pfl_sync #(.W($bits(pins_t)), .RST_VAL(PINS_IDLE)) u_sync_pins (
    .clk_i, .rst_ni, .d_i(pins_raw), .q_o(pins_s)
  );

  pfl_sync #(.W(AW+DW), .RST_VAL('0)) u_sync_bus (
    .clk_i, .rst_ni, .d_i({addr_i, dq_i}), .q_o(bus_s)
  );

  pfl_sync #(.W(1), .RST_VAL(1'b0)) u_sync_mode (
    .clk_i, .rst_ni, .d_i(sync_mode_i), .q_o(mode_s)
  );

  assign addr_s = bus_s[AW+DW-1:DW];
  assign dq_s   = bus_s[DW-1:0];

  pfl_decode u_decode (.pins_i(pins_s), .op_o(op));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_p <= PINS_IDLE;
      addr_p <= '0;
      dq_p   <= '0;
      eff_p  <= '0;
      op_p   <= OP_RESET;
    end else begin
      pins_p <= pins_s;
      addr_p <= addr_s;
      dq_p   <= dq_s;
      eff_p  <= eff_addr;
      op_p   <= op;
    end
  end

  pfl_addr_latch #(.AW(AW)) u_addr (
    .clk_i, .rst_ni,
    .sync_mode_i (mode_s),
    .dev_rst_n_i (pins_s.rst_n),
    .adv_n_i     (pins_s.adv_n),
    .adv_prev_n_i(pins_p.adv_n),
    .bclk_rise_i (pins_s.bclk && !pins_p.bclk),
    .addr_i      (addr_s),
    .addr_prev_i (addr_p),
    .addr_o      (eff_addr)
  );

  // first rise of WE# or CE# closing a write; a joint rise is one strobe
  assign wr_stb = (op_p == OP_WRITE) && pins_s.rst_n &&
                  ((pins_s.we_n && !pins_p.we_n) || (pins_s.ce_n && !pins_p.ce_n));

  generate
    if (BANK_BITS > 0) begin : g_bank
      assign ridx = {eff_addr[AW-1 -: BANK_BITS], eff_addr[WORD_BITS-1:0]};
      assign widx = {eff_p[AW-1 -: BANK_BITS], eff_p[WORD_BITS-1:0]};
    end else begin : g_flat
      assign ridx = eff_addr[WORD_BITS-1:0];
      assign widx = eff_p[WORD_BITS-1:0];
    end
  endgenerate

  pfl_array #(.DW(DW), .IDX_W(IDX_W)) u_array (
    .clk_i, .rst_ni,
    .we_i   (wr_stb),
    .widx_i (widx),
    .wdata_i(dq_p),
    .ridx_i (ridx),
    .rdata_o(rdata)
  );

  assign dq_o      = rdata;
  assign dq_oe_o   = (op == OP_READ);
  assign wait_oe_o = (op == OP_READ);
  assign wait_o    = WAIT_IDLE;
  assign bus_op_o  = op;
endmodule

// File: rtl/pfl_front_chk.sv
module pfl_front_chk #(
  parameter logic WAIT_IDLE = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       oe_ni,
  input logic       we_ni,
  input logic       dev_rst_ni,
  input logic       dq_oe_o,
  input logic       wait_o,
  input logic       wait_oe_o,
  input logic [2:0] bus_op_o
);
  logic [1:0] age_q;
  logic       live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign live = (age_q == 2'd3);

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(!dev_rst_ni, 2) |-> bus_op_o == 3'd4 && !dq_oe_o && !wait_oe_o); // R1

  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(dev_rst_ni && !ce_ni && !oe_ni && we_ni, 2)
      |-> dq_oe_o && wait_oe_o && wait_o == WAIT_IDLE); // R2

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(dev_rst_ni && !ce_ni && oe_ni && !we_ni, 2)
      |-> bus_op_o == 3'd2 && !dq_oe_o && !wait_oe_o); // R3

  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(dev_rst_ni && ce_ni, 2) |-> bus_op_o == 3'd0 && !dq_oe_o); // R4

  AST_UNDEF_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(dev_rst_ni && !ce_ni && !oe_ni && !we_ni, 2)
      |-> bus_op_o == 3'd0 && !wait_oe_o); // R5
endmodule

bind pfl_front pfl_front_chk #(.WAIT_IDLE(WAIT_IDLE)) u_chk (
  .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .dev_rst_ni,
  .dq_oe_o, .wait_o, .wait_oe_o, .bus_op_o
);

// File: tb/sim_pfl_front.sv
module sim_pfl_front;
  localparam int AW = 23;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, bclk = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, adv_n = 1'b0, drst_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, wt, wt_oe;
  logic [2:0] op;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pfl_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(mode), .bus_clk_i(bclk),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n), .adv_ni(adv_n),
    .dev_rst_ni(drst_n), .addr_i(addr), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .wait_o(wt), .wait_oe_o(wt_oe),
    .bus_op_o(op)
  );

  typedef struct packed {
    logic        rst_n, ce_n, oe_n, we_n;
    logic [22:0] addr;
    logic [15:0] dq;
    logic [2:0]  exp_op;
    logic        exp_oe;
    logic        chk_dq;
    logic [15:0] exp_dq;
  } vec_t;

  // ADV held low, asynchronous mode
  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 23'h000005, 16'hA5A5, 3'd4, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 1'b1, 1'b1, 1'b1, 23'h000005, 16'hA5A5, 3'd0, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 1'b0, 23'h000005, 16'hA5A5, 3'd2, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 1'b1, 23'h000005, 16'hA5A5, 3'd3, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 1'b1, 1'b1, 1'b1, 23'h000005, 16'h0000, 3'd0, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 1'b0, 23'h400005, 16'h5A5A, 3'd2, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 1'b1, 1'b1, 1'b1, 23'h400005, 16'h5A5A, 3'd0, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 1'b1, 23'h000005, 16'h0000, 3'd1, 1'b1, 1'b1, 16'hA5A5},
    '{1'b1, 1'b0, 1'b0, 1'b1, 23'h400005, 16'h0000, 3'd1, 1'b1, 1'b1, 16'h5A5A},
    '{1'b1, 1'b0, 1'b0, 1'b0, 23'h400005, 16'h0000, 3'd0, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 1'b1, 23'h000001, 16'h0000, 3'd1, 1'b1, 1'b1, 16'h0000},
    '{1'b0, 1'b0, 1'b0, 1'b1, 23'h000001, 16'h0000, 3'd4, 1'b0, 1'b0, 16'h0000}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pins(input logic r, input logic c, input logic o, input logic w);
    drst_n = r; ce_n = c; oe_n = o; we_n = w;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; dq_in = d;
    pins(1, 0, 1, 0); settle();
    pins(1, 0, 1, 1); settle();
    pins(1, 1, 1, 1); settle();
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] e);
    addr = a;
    pins(1, 0, 0, 1); settle();
    chk(req, "read data", 32'(dq_out), 32'(e));
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd4:    return "R1";
      3'd1:    return "R2";
      3'd2:    return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R4", "idle op after reset", 32'(op), 32'd0);
    chk("R4", "idle dq_oe after reset", 32'(dq_oe), 32'd0);

    // table walk: R1 R2 R3 R4 R8, row 6 is a joint WE/CE rise, row 9 is R5
    for (int i = 0; i < 12; i++) begin
      pins(VEC[i].rst_n, VEC[i].ce_n, VEC[i].oe_n, VEC[i].we_n);
      addr = VEC[i].addr; dq_in = VEC[i].dq;
      settle();
      chk(tag_of(VEC[i].exp_op), "op", 32'(op), 32'(VEC[i].exp_op));
      chk(tag_of(VEC[i].exp_op), "dq_oe", 32'(dq_oe), 32'(VEC[i].exp_oe));
      chk(tag_of(VEC[i].exp_op), "wait_oe", 32'(wt_oe), 32'(VEC[i].exp_oe));
      if (VEC[i].chk_dq) begin
        chk("R8", "bank word", 32'(dq_out), 32'(VEC[i].exp_dq));
        chk("R10", "wait level", 32'(wt), 32'd0);
      end
    end

    // R5 directed: undefined combination
    pins(1, 0, 0, 0); settle();
    chk("R5", "undefined op", 32'(op), 32'd0);
    chk("R5", "undefined dq_oe", 32'(dq_oe), 32'd0);
    pins(1, 1, 1, 1); settle();

    // R1: write attempted under device reset is not stored
    addr = 23'h000002; dq_in = 16'h1234;
    pins(0, 0, 1, 0); settle();
    pins(0, 0, 1, 1); settle();
    pins(0, 1, 1, 1); settle();
    rd("R1", 23'h000002, 16'h0000);

    // R9: device reset keeps the array
    rd("R9", 23'h000005, 16'hA5A5);

    // R3: joint rise stored exactly the last word; CE-only close also stores
    addr = 23'h000006; dq_in = 16'h0F0F;
    pins(1, 0, 1, 0); settle();
    pins(1, 1, 1, 0); settle();
    pins(1, 1, 1, 1); settle();
    rd("R3", 23'h000006, 16'h0F0F);
    rd("R3", 23'h400005, 16'h5A5A);

    // R6: asynchronous flow-through and hold
    wr(23'h000003, 16'h3333);
    wr(23'h000004, 16'h4444);
    rd("R6", 23'h000003, 16'h3333);
    adv_n = 1'b1; settle();
    addr = 23'h000004; settle();
    chk("R6", "held address", 32'(dq_out), 32'h3333);
    adv_n = 1'b0; settle();
    chk("R6", "flow address", 32'(dq_out), 32'h4444);

    // R7: synchronous capture
    adv_n = 1'b1; addr = 23'h000003; settle();
    mode = 1'b1; settle();
    adv_n = 1'b0; settle();
    adv_n = 1'b1; settle();
    addr = 23'h000004; settle();
    chk("R7", "ADV rise capture", 32'(dq_out), 32'h3333);
    adv_n = 1'b0; settle();
    chk("R7", "no capture yet", 32'(dq_out), 32'h3333);
    bclk = 1'b1; settle();
    bclk = 1'b0; addr = 23'h000003; settle();
    chk("R7", "clock capture", 32'(dq_out), 32'h4444);
    bclk = 1'b1; settle();
    chk("R7", "second edge ignored", 32'(dq_out), 32'h4444);
    adv_n = 1'b1; settle();
    chk("R7", "ADV rise after clock ignored", 32'(dq_out), 32'h4444);
    bclk = 1'b0; mode = 1'b0; adv_n = 1'b0; settle();

    // R9: system reset clears the array
    pins(1, 1, 1, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    settle();
    rd("R9", 23'h000005, 16'h0000);
    rd("R9", 23'h400005, 16'h0000);
    chk("R10", "wait level on read", 32'(wt), 32'd0);
    chk("R2", "wait driven on read", 32'(wt_oe), 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule